// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block moves a small system between its running state and a low-power sleep state. Firmware asks for sleep by pulsing a request that sets the sleep flag. The sequencer does not stop the processor in the middle of an instruction. It waits for an instruction-boundary indication and then stops the CPU. One cycle later it powers down the fast oscillator, the flash array and the voltage reference. The slow clock domain and the supply monitor are not controlled here and stay up.

While the system sleeps, a counter runs on the slow-clock tick. Near the end of each refresh period it switches the reference back on for a short window, so that the reference's held voltage is renewed. Only an interrupt or a reset ends sleep. On an interrupt, the reference and the fast oscillator come back first. The CPU stays stopped and the flash stays off until a settle count has run out. Then both are released together and the sleep flag clears. If an interrupt arrives while entry is still in progress, the entry is abandoned and the block returns directly to run.

Top module: `slp_seq_top`

## Requirements
- R1: After a synchronous reset, every output is 0. This means the CPU runs, all units are powered and the sleep flag is clear.
- R2: A `sleep_req` pulse in the run state sets `sleep_flag` on the next cycle. `cpu_stop` stays 0 until `insn_bound` is seen.
- R3: When `insn_bound` is 1 while waiting, `cpu_stop` becomes 1 on the next cycle and all units are still powered. On the cycle after that, `fosc_pd`, `flash_pd` and `vref_pd` all become 1.
- R4: `sleep_req` has no effect outside the run state. A `sleep_req` pulse during sleep or during wake-up changes no output.
- R5: During sleep, `vref_pd` drops to 0 for the last REFR_LEN slow ticks of every REFR_PERIOD ticks. Ticks are counted from a zero count at each sleep entry. A tick that takes the count to REFR_PERIOD−REFR_LEN switches the reference on. The tick that completes the period switches it off again.
- R6: Any set bit of `wake_irq` during sleep drops `fosc_pd` and `vref_pd` to 0 on the next cycle, while `cpu_stop` and `flash_pd` stay 1. After SETTLE cycles in this state, `cpu_stop`, `flash_pd` and `sleep_flag` all drop to 0 together.
- R7: A `wake_irq` bit seen while waiting for the boundary or during the one-cycle stop stage returns the block to run on the next cycle, with `sleep_flag` cleared. This wake takes priority over `insn_bound` in the same cycle.
- R8: A reset asserted in any state brings all outputs to 0 at the next clock edge.
- R9: `wake_irq` and `slow_tick` in the run state, and `wake_irq` during wake-up, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Firmware pulse that sets the sleep flag |
| insn_bound | input | 1 | CPU is at an instruction boundary |
| wake_irq | input | N_WAKE | Interrupt wake sources, any bit wakes |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| cpu_stop | output | 1 | Holds the CPU stopped |
| fosc_pd | output | 1 | Fast oscillator power-down |
| flash_pd | output | 1 | Flash array power-down |
| vref_pd | output | 1 | Voltage reference power-down |
| sleep_flag | output | 1 | Current value of the sleep flag |

## Verification
The bench builds the block with REFR_PERIOD=8, REFR_LEN=2, SETTLE=4 and N_WAKE=3. With these values a full refresh window, including its wrap back to off, takes only a handful of slow ticks. The complete wake settle can be observed and counted cycle by cycle. The short period also lets a randomized run pass through many sleep entries, aborts, refresh windows and wake-ups, and reach the end of the settle count and the refresh wrap many times.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_STOP  = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAKE  = 3'd4
  } slp_state_e;
endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       insn_bound,
  input  logic       wake_any,
  output slp_state_e state_q,
  output slp_state_e state_d,
  output logic       flag_q
);
  localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);

  logic [SW-1:0] settle_q, settle_d;
  logic          flag_d;

  always_comb begin
    state_d  = state_q;
    flag_d   = flag_q;
    settle_d = settle_q;
    case (state_q)
      ST_RUN: begin
        if (sleep_req) begin
          state_d = ST_WAIT;
          flag_d  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (wake_any) begin
          state_d = ST_RUN;
          flag_d  = 1'b0;
        end else if (insn_bound) begin
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (wake_any) begin
          state_d = ST_RUN;
          flag_d  = 1'b0;
        end else begin
          state_d = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wake_any) begin
          state_d  = ST_WAKE;
          settle_d = '0;
        end
      end
      ST_WAKE: begin
        if (settle_q == SETTLE_LAST) begin
          state_d = ST_RUN;
          flag_d  = 1'b0;
        end else begin
          settle_d = settle_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_RUN;
        flag_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      flag_q   <= 1'b0;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      flag_q   <= flag_d;
      settle_q <= settle_d;
    end
  end
endmodule

// File: rtl/slp_refresh.sv
module slp_refresh
  import slp_pkg::*;
#(
  parameter int REFR_PERIOD = 64,
  parameter int REFR_LEN    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  slp_state_e state_q,
  input  logic       slow_tick,
  output logic       refr_on_d
);
  localparam int CW = (REFR_PERIOD > 1) ? $clog2(REFR_PERIOD) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(REFR_PERIOD - 1);
  localparam logic [CW-1:0] ON_FROM  = CW'(REFR_PERIOD - REFR_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (state_q != ST_SLEEP) begin
      cnt_d = '0;
    end else if (slow_tick) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  assign refr_on_d = (cnt_d >= ON_FROM);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/slp_seq_top.sv
module slp_seq_top
  import slp_pkg::*;
#(
  parameter int N_WAKE      = 4,
  parameter int REFR_PERIOD = 64,
  parameter int REFR_LEN    = 2,
  parameter int SETTLE      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              insn_bound,
  input  logic [N_WAKE-1:0] wake_irq,
  input  logic              slow_tick,
  output logic              cpu_stop,
  output logic              fosc_pd,
  output logic              flash_pd,
  output logic              vref_pd,
  output logic              sleep_flag
);
  slp_state_e state_q, state_d;
  logic       wake_any, refr_on_d;

  assign wake_any = |wake_irq;

  slp_ctrl #(.SETTLE(SETTLE)) i_ctrl (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .insn_bound(insn_bound),
    .wake_any(wake_any), .state_q(state_q), .state_d(state_d),
    .flag_q(sleep_flag)
  );

  slp_refresh #(.REFR_PERIOD(REFR_PERIOD), .REFR_LEN(REFR_LEN)) i_refr (
    .clk(clk), .rst(rst), .state_q(state_q), .slow_tick(slow_tick),
    .refr_on_d(refr_on_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_stop <= 1'b0;
      fosc_pd  <= 1'b0;
      flash_pd <= 1'b0;
      vref_pd  <= 1'b0;
    end else begin
      cpu_stop <= (state_d == ST_STOP) || (state_d == ST_SLEEP) || (state_d == ST_WAKE);
      fosc_pd  <= (state_d == ST_SLEEP);
      flash_pd <= (state_d == ST_SLEEP) || (state_d == ST_WAKE);
      vref_pd  <= (state_d == ST_SLEEP) && !refr_on_d;
    end
  end
endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk (
  input logic clk,
  input logic rst,
  input logic cpu_stop,
  input logic fosc_pd,
  input logic flash_pd,
  input logic vref_pd,
  input logic sleep_flag
);
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!cpu_stop && !fosc_pd && !flash_pd && !vref_pd && !sleep_flag));

  a_r2_stop_needs_flag: assert property (@(posedge clk) disable iff (rst)
    cpu_stop |-> sleep_flag);

  a_r3_stop_before_pd: assert property (@(posedge clk) disable iff (rst)
    $rose(fosc_pd) |-> $past(cpu_stop));

  a_r6_fosc_off_holds_cpu: assert property (@(posedge clk) disable iff (rst)
    fosc_pd |-> (cpu_stop && flash_pd));

  a_r5_vref_off_only_asleep: assert property (@(posedge clk) disable iff (rst)
    vref_pd |-> fosc_pd);

  a_r6_flash_with_release: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_pd) |-> !cpu_stop);

  a_r7_release_clears_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stop) |-> (!sleep_flag && !fosc_pd && !flash_pd));
endmodule

bind slp_seq_top slp_seq_chk i_chk (
  .clk(clk), .rst(rst), .cpu_stop(cpu_stop), .fosc_pd(fosc_pd),
  .flash_pd(flash_pd), .vref_pd(vref_pd), .sleep_flag(sleep_flag)
);

// File: tb/test_slp_seq_top.sv
`timescale 1ns/1ps
module test_slp_seq_top;
  localparam int NW = 3, RP = 8, RL = 2, ST = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sleep_req = 1'b0, insn_bound = 1'b0, slow_tick = 1'b0;
  logic [NW-1:0] wake_irq = '0;
  logic cpu_stop, fosc_pd, flash_pd, vref_pd, sleep_flag;

  always #2.5 clk = ~clk;

  slp_seq_top #(.N_WAKE(NW), .REFR_PERIOD(RP), .REFR_LEN(RL), .SETTLE(ST)) i_slp_seq_top (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .insn_bound(insn_bound),
    .wake_irq(wake_irq), .slow_tick(slow_tick), .cpu_stop(cpu_stop),
    .fosc_pd(fosc_pd), .flash_pd(flash_pd), .vref_pd(vref_pd),
    .sleep_flag(sleep_flag)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;
  string tag = "R1";

  // reference model: 0 run, 1 wait, 2 stop, 3 sleep, 4 wake
  int m_st = 0, m_flag = 0, m_rc = 0, m_sc = 0;

  function automatic logic [4:0] model_out();
    logic refr;
    refr = (m_st == 3) && (m_rc >= RP - RL);
    return {m_flag[0], (m_st >= 2), (m_st == 3), (m_st >= 3), (m_st == 3) && !refr};
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_st = 0; m_flag = 0; m_rc = 0; m_sc = 0;
    end else begin
      case (m_st)
        0: if (sleep_req) begin m_st = 1; m_flag = 1; end
        1: if (|wake_irq) begin m_st = 0; m_flag = 0; end
           else if (insn_bound) m_st = 2;
        2: if (|wake_irq) begin m_st = 0; m_flag = 0; end
           else begin m_st = 3; m_rc = 0; end
        3: if (|wake_irq) begin m_st = 4; m_sc = 0; end
           else if (slow_tick) m_rc = (m_rc == RP - 1) ? 0 : m_rc + 1;
        default: if (m_sc == ST - 1) begin m_st = 0; m_flag = 0; end
                 else m_sc++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if ({sleep_flag, cpu_stop, fosc_pd, flash_pd, vref_pd} !== model_out()) begin
        errors++;
        $display("FAIL %s model compare: actual %b expected %b", tag,
                 {sleep_flag, cpu_stop, fosc_pd, flash_pd, vref_pd}, model_out());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most 50000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // expected order: {sleep_flag, cpu_stop, fosc_pd, flash_pd, vref_pd}
  task automatic chk(input logic [4:0] exp, input string r);
    checks++;
    if ({sleep_flag, cpu_stop, fosc_pd, flash_pd, vref_pd} !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", r,
               {sleep_flag, cpu_stop, fosc_pd, flash_pd, vref_pd}, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();  sleep_req = 1; cyc(1); sleep_req = 0; cyc(1); endtask
  task automatic pulse_bnd();  insn_bound = 1; cyc(1); insn_bound = 0; cyc(1); endtask
  task automatic pulse_wake(input logic [NW-1:0] w); wake_irq = w; cyc(1); wake_irq = '0; cyc(1); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin slow_tick = 1; cyc(1); slow_tick = 0; cyc(1); end
  endtask

  initial begin
    cyc(3); rst = 0; cyc(1);
    tag = "R1"; chk(5'b00000, "R1");
    tag = "R9"; pulse_wake(3'b001); chk(5'b00000, "R9");
    ticks(3); chk(5'b00000, "R9");
    tag = "R2"; pulse_req(); chk(5'b10000, "R2");
    cyc(3); chk(5'b10000, "R2");
    tag = "R3"; pulse_bnd();
    // after pulse_bnd's two negedges the stop stage has already passed
    chk(5'b11111, "R3");
    tag = "R4"; pulse_req(); chk(5'b11111, "R4");
    tag = "R5"; ticks(RP - RL - 1); chk(5'b11111, "R5");
    ticks(1); chk(5'b11110, "R5");
    ticks(RL - 1); chk(5'b11110, "R5");
    ticks(1); chk(5'b11111, "R5");
    tag = "R6"; wake_irq = 3'b100; cyc(1); wake_irq = '0;
    chk(5'b11010, "R6");
    cyc(ST - 1); chk(5'b11010, "R6");
    cyc(1); chk(5'b00000, "R6");
    tag = "R3"; sleep_req = 1; cyc(1); sleep_req = 0;
    insn_bound = 1; cyc(1); insn_bound = 0;
    chk(5'b11000, "R3");
    cyc(1); chk(5'b11111, "R3");
    tag = "R9"; wake_irq = 3'b010; cyc(1); wake_irq = '0; cyc(1);
    wake_irq = 3'b001; cyc(1); wake_irq = '0; chk(5'b11010, "R9");
    tag = "R4"; sleep_req = 1; cyc(1); sleep_req = 0; chk(5'b11010, "R4");
    cyc(ST); chk(5'b00000, "R4");
    tag = "R7"; pulse_req(); pulse_wake(3'b010); chk(5'b00000, "R7");
    sleep_req = 1; cyc(1); sleep_req = 0; insn_bound = 1; cyc(1); insn_bound = 0;
    wake_irq = 3'b001; cyc(1); wake_irq = '0; chk(5'b00000, "R7");
    sleep_req = 1; cyc(1); sleep_req = 0;
    insn_bound = 1; wake_irq = 3'b100; cyc(1); insn_bound = 0; wake_irq = '0;
    chk(5'b00000, "R7");
    tag = "R5"; pulse_req(); pulse_bnd(); ticks(3);
    pulse_wake(3'b001); cyc(ST); chk(5'b00000, "R5");
    pulse_req(); pulse_bnd(); ticks(RP - RL - 1); chk(5'b11111, "R5");
    ticks(1); chk(5'b11110, "R5");
    tag = "R8"; rst = 1; cyc(1); rst = 0; chk(5'b00000, "R8");
    cyc(1); chk(5'b00000, "R8");
    tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      sleep_req  = ($urandom_range(0, 9) == 0);
      insn_bound = ($urandom_range(0, 3) == 0);
      slow_tick  = ($urandom_range(0, 2) == 0);
      wake_irq   = ($urandom_range(0, 29) == 0) ? NW'($urandom_range(1, 7)) : '0;
      rst        = ($urandom_range(0, 499) == 0);
      cyc(1);
    end
    rst = 0; sleep_req = 0; insn_bound = 0; slow_tick = 0; wake_irq = '0;
    cyc(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule